// File: doc/BRIEF.md
# Burst Segment CRC-16 Accumulator

This block keeps a running 16-bit CRC over every data word moved during one DMA burst segment. Both directions of the transfer use it. The transmit path reads the result and drives it as the last bus word. The receive path compares the word it collects against the local value.

A segment opens when the active-low burst acknowledge goes low and closes when it returns high. When the acknowledge asserts, the register takes a fixed seed. While the acknowledge is low, each word-valid pulse folds one 16-bit word into the register within a single clock. The strobe-edge synchroniser outside this block turns both strobe edges into these pulses in the system clock domain.

When the acknowledge deasserts, the running value is captured as the segment result and a one-cycle pulse announces it. A compare port checks a CRC word against the captured result. A mismatch raises an error flag that stays set until the next segment opens.

Top module: `burst_crc_acc`

## Requirements
- R1: After reset, `crc_o` is 0x4ABA, and `final_crc_o`, `final_vld_o` and `crc_err_o` are 0.
- R2: In the first clock where `burst_ack_ni` is sampled low after being high, the register is reseeded to 0x4ABA. `crc_o` shows the seed after that edge if no word came in that clock.
- R3: Each accepted word is folded in with polynomial x^16+x^12+x^5+1 (0x1021), word bit 15 first and no reflection or final inversion. `crc_o` shows the new value one clock after `word_vld_i`.
- R4: A `word_vld_i` pulse while `burst_ack_ni` is high is ignored, and `crc_o` does not change.
- R5: A word presented in the same clock the acknowledge asserts is folded into the fresh seed.
- R6: In the first clock where `burst_ack_ni` is sampled high after being low, `final_crc_o` captures `crc_o`. `final_vld_o` is high for exactly the following cycle.
- R7: `final_crc_o` holds its value until the next deassertion of the acknowledge.
- R8: A `cmp_vld_i` pulse whose `cmp_crc_i` differs from `final_crc_o` sets `crc_err_o` one clock later. A matching word leaves the flag unchanged.
- R9: `crc_err_o` stays set until the clock where the acknowledge asserts, which clears it.
- R10: A compare presented in the same clock the acknowledge asserts is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_ack_ni | input | 1 | Burst acknowledge, active low; low marks the segment |
| word_vld_i | input | 1 | One pulse per valid strobe edge |
| word_i | input | 16 | Data word moved on that strobe edge |
| cmp_vld_i | input | 1 | Compare request pulse |
| cmp_crc_i | input | 16 | CRC word to check against the segment result |
| crc_o | output | 16 | Running CRC register |
| final_crc_o | output | 16 | CRC captured at acknowledge deassertion |
| final_vld_o | output | 1 | One-cycle pulse marking a fresh `final_crc_o` |
| crc_err_o | output | 1 | Sticky mismatch flag |

## Verification
The checker watches the cycle-level rules on every clock:
- reseeding on acknowledge assertion;
- a frozen register while the acknowledge is high;
- capture and the one-cycle pulse on deassertion, with the result held between segments;
- the error flag being set by a mismatch, cleared at assertion and held in between.

The arithmetic of the fold itself, MSB-first ordering and polynomial, can only be shown by the bench. It compares the register against an independently computed CRC across random segments. It also drives directed cases: empty segments, a word in the assertion clock, and compares colliding with assertion.

// File: rtl/burst_crc_pkg.sv
package burst_crc_pkg;
  localparam int unsigned CRC_W    = 16;
  localparam int unsigned DATA_W   = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'h4ABA;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    logic open_seg;   // acknowledge just asserted
    logic close_seg;  // acknowledge just deasserted
    logic active;     // acknowledge asserted this cycle
  } seg_evt_t;
endpackage

// File: rtl/seg_edge_det.sv
module seg_edge_det
  import burst_crc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ack_ni,
  output seg_evt_t evt_o
);
  logic ack_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_n_q <= 1'b1;
    else         ack_n_q <= ack_ni;
  end

  always_comb begin
    evt_o.open_seg  = ack_n_q & ~ack_ni;
    evt_o.close_seg = ~ack_n_q & ack_ni;
    evt_o.active    = ~ack_ni;
  end
endmodule

// File: rtl/crc_fold.sv
// Parallel multi-bit CRC update, MSB of the word first.
module crc_fold #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned DATA_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] chain [DATA_W+1];

  assign chain[0] = crc_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic fb;
    assign fb = chain[i][CRC_W-1] ^ data_i[DATA_W-1-i];
    assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = chain[DATA_W];
endmodule

// File: rtl/crc_cmp.sv
module crc_cmp #(
  parameter int unsigned CRC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cmp_vld_i,
  input  logic [CRC_W-1:0] cmp_crc_i,
  input  logic [CRC_W-1:0] ref_crc_i,
  output logic             err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 err_q <= 1'b0;
    else if (clr_i)                              err_q <= 1'b0;
    else if (cmp_vld_i && cmp_crc_i != ref_crc_i) err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/burst_crc_acc.sv
module burst_crc_acc
  import burst_crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              burst_ack_ni,
  input  logic              word_vld_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              cmp_vld_i,
  input  logic [CRC_W-1:0]  cmp_crc_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic [CRC_W-1:0]  final_crc_o,
  output logic              final_vld_o,
  output logic              crc_err_o
);
  seg_evt_t evt;
  crc_t     crc_q, crc_base, crc_next, final_q;
  logic     final_vld_q;

  seg_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_ni (burst_ack_ni),
    .evt_o  (evt)
  );

  // a word in the opening cycle folds into the seed
  assign crc_base = evt.open_seg ? CRC_SEED : crc_q;

  crc_fold #(
    .CRC_W  (CRC_W),
    .DATA_W (DATA_W),
    .POLY   (CRC_POLY)
  ) u_fold (
    .crc_i  (crc_base),
    .data_i (word_i),
    .crc_o  (crc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q       <= CRC_SEED;
      final_q     <= '0;
      final_vld_q <= 1'b0;
    end else begin
      if (evt.active && word_vld_i) crc_q <= crc_next;
      else if (evt.open_seg)        crc_q <= CRC_SEED;
      if (evt.close_seg) final_q <= crc_q;
      final_vld_q <= evt.close_seg;
    end
  end

  crc_cmp #(.CRC_W(CRC_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (evt.open_seg),
    .cmp_vld_i (cmp_vld_i),
    .cmp_crc_i (cmp_crc_i),
    .ref_crc_i (final_q),
    .err_o     (crc_err_o)
  );

  assign crc_o       = crc_q;
  assign final_crc_o = final_q;
  assign final_vld_o = final_vld_q;
endmodule

// File: rtl/burst_crc_acc_chk.sv
module burst_crc_acc_chk
  import burst_crc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              burst_ack_ni,
  input logic              word_vld_i,
  input logic              cmp_vld_i,
  input logic [CRC_W-1:0]  cmp_crc_i,
  input logic [CRC_W-1:0]  crc_o,
  input logic [CRC_W-1:0]  final_crc_o,
  input logic              final_vld_o,
  input logic              crc_err_o
);
  logic ack_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_prev <= 1'b1;
    else         ack_prev <= burst_ack_ni;
  end

  logic opening, closing;
  assign opening = ack_prev & ~burst_ack_ni;
  assign closing = ~ack_prev & burst_ack_ni;

  assert_seed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opening && !word_vld_i) |=> crc_o == CRC_SEED);

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_ack_ni && ack_prev) |=> $stable(crc_o));

  assert_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    closing |=> (final_vld_o && final_crc_o == $past(crc_o)));

  assert_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !closing |=> !final_vld_o);

  assert_final_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !closing |=> $stable(final_crc_o));

  assert_mismatch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_vld_i && cmp_crc_i != final_crc_o && !opening) |=> crc_err_o);

  assert_err_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opening |=> !crc_err_o);

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_err_o && !opening) |=> crc_err_o);
endmodule

bind burst_crc_acc burst_crc_acc_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .burst_ack_ni (burst_ack_ni),
  .word_vld_i   (word_vld_i),
  .cmp_vld_i    (cmp_vld_i),
  .cmp_crc_i    (cmp_crc_i),
  .crc_o        (crc_o),
  .final_crc_o  (final_crc_o),
  .final_vld_o  (final_vld_o),
  .crc_err_o    (crc_err_o)
);

// File: tb/tb_burst_crc_acc.sv
module tb_burst_crc_acc;
  localparam int unsigned W = 16;
  localparam logic [W-1:0] SEED = 16'h4ABA;
  localparam logic [W-1:0] POLY = 16'h1021;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic burst_ack_ni = 1'b1, word_vld_i = 1'b0, cmp_vld_i = 1'b0;
  logic [W-1:0] word_i = '0, cmp_crc_i = '0;
  logic [W-1:0] crc_o, final_crc_o;
  logic final_vld_o, crc_err_o;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_tag = "R1";

  logic [W-1:0] m_crc = SEED, m_fin = '0;
  logic m_vld = 1'b0, m_err = 1'b0, m_ackp = 1'b1;

  always #4 clk_i = ~clk_i;

  burst_crc_acc dut (.*);

  function automatic logic [W-1:0] ref_fold(logic [W-1:0] c, logic [W-1:0] d);
    for (int i = W - 1; i >= 0; i--) begin
      logic fb;
      fb = c[W-1] ^ d[i];
      c = {c[W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    check(cur_tag, "crc_o", crc_o, m_crc);
    check(cur_tag, "final_crc_o", final_crc_o, m_fin);
    check(cur_tag, "final_vld_o", {15'b0, final_vld_o}, {15'b0, m_vld});
    check(cur_tag, "crc_err_o", {15'b0, crc_err_o}, {15'b0, m_err});
  endtask

  // one clock: check last edge's result, drive, advance model
  task automatic step(logic ackn, logic v, logic [W-1:0] w, logic cv, logic [W-1:0] cw);
    logic op, cl;
    logic [W-1:0] nc;
    @(negedge clk_i);
    check_all();
    burst_ack_ni = ackn; word_vld_i = v; word_i = w; cmp_vld_i = cv; cmp_crc_i = cw;
    op = m_ackp & ~ackn;
    cl = ~m_ackp & ackn;
    nc = op ? SEED : m_crc;
    if (!ackn && v) nc = ref_fold(nc, w);
    if (op) m_err = 1'b0;
    else if (cv && cw != m_fin) m_err = 1'b1;
    if (cl) m_fin = m_crc;
    m_vld = cl;
    m_crc = nc;
    m_ackp = ackn;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, '0, 1'b0, '0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] exp_one;
    void'($urandom(32'd1187));
    #20;
    cur_tag = "R1";
    check("R1", "reset crc_o", crc_o, SEED);
    check("R1", "reset final", final_crc_o, '0);
    check("R1", "reset vld/err", {14'b0, final_vld_o, crc_err_o}, '0);
    rst_ni = 1'b1;

    // R2: empty segment yields the seed
    cur_tag = "R2";
    idle(2);
    step(1'b0, 1'b0, '0, 1'b0, '0);
    step(1'b0, 1'b0, '0, 1'b0, '0);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    check("R2", "empty segment final", final_crc_o, SEED);

    // R3/R5: single word in the assertion cycle
    cur_tag = "R5";
    exp_one = ref_fold(SEED, 16'h1234);
    step(1'b0, 1'b1, 16'h1234, 1'b0, '0);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    check("R5", "word in open cycle crc_o", crc_o, exp_one);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    check("R3", "single word final", final_crc_o, exp_one);

    // R4: words with acknowledge high are dropped
    cur_tag = "R4";
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 16'(i * 16'h1111), 1'b0, '0);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    check("R4", "idle words ignored", crc_o, exp_one);

    // R8: matching compare keeps flag low, mismatch sets it
    cur_tag = "R8";
    step(1'b1, 1'b0, '0, 1'b1, exp_one);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    check("R8", "match keeps err low", {15'b0, crc_err_o}, '0);
    step(1'b1, 1'b0, '0, 1'b1, exp_one ^ 16'h0001);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    check("R8", "mismatch sets err", {15'b0, crc_err_o}, 16'd1);

    // R9: sticky through later matches, cleared on open
    cur_tag = "R9";
    step(1'b1, 1'b0, '0, 1'b1, exp_one);
    idle(3);
    check("R9", "err sticky", {15'b0, crc_err_o}, 16'd1);
    // R10: mismatching compare in the open cycle is ignored
    cur_tag = "R10";
    step(1'b0, 1'b0, '0, 1'b1, 16'hDEAD);
    step(1'b0, 1'b0, '0, 1'b0, '0);
    check("R10", "open clears err, cmp ignored", {15'b0, crc_err_o}, '0);
    // R7: final value held during the open segment
    cur_tag = "R7";
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 16'($urandom), 1'b0, '0);
    check("R7", "final held mid segment", final_crc_o, exp_one);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    idle(2);

    // random segments with gaps, idle words and compares
    cur_tag = "R6";
    for (int seg = 0; seg < 300; seg++) begin
      int len;
      len = int'($urandom_range(0, 40));
      step(1'b0, 1'($urandom), 16'($urandom), 1'($urandom_range(0, 3) == 0), 16'($urandom));
      for (int i = 0; i < len; i++)
        step(1'b0, 1'($urandom_range(0, 3) != 0), 16'($urandom), 1'($urandom_range(0, 7) == 0),
             ($urandom_range(0, 1) != 0) ? m_fin : 16'($urandom));
      for (int i = 0; i < int'($urandom_range(1, 5)); i++)
        step(1'b1, 1'($urandom), 16'($urandom), 1'($urandom_range(0, 1) == 0),
             ($urandom_range(0, 1) != 0) ? m_crc : 16'($urandom));
    end
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule